// File: doc/BRIEF.md
# Hardware-Thread Register Context Switcher

This block keeps a separate architectural register context for each of several hardware threads inside one register array, and it picks the thread that feeds a shared pipeline on each cycle. The current context pointer (`issue_tid`) selects which context the two read ports see. Switching threads therefore moves only a pointer, and no state is saved or restored. Writeback names its target context explicitly with `wr_tid`, so a result that arrives after the pointer has moved still lands in its own thread's context. Each thread also owns a program-counter register. Reset loads it from a per-thread start-address input, and the block presents the PC of the issuing thread on `issue_pc`.

The mode input chooses the switch policy. In fine-grain mode (`mode_coarse`=0) the block round-robins every cycle over the eligible threads, starting after the current one. A thread is eligible when it is ready and not in a long-latency stall. In coarse-grain mode (`mode_coarse`=1) the block stays on the current thread until that thread raises its long-stall input. It then moves to the next eligible thread in the same clock edge. A short stall on the current thread (ready low, no long stall) only inserts a bubble.

The scheduler is a three-state machine. ST_IDLE means nothing is issued. ST_ISSUE means `issue_valid` is high. ST_HOLD means a coarse-mode bubble on the current thread. Its transitions are:
- GO_ISSUE: a thread is chosen, to ST_ISSUE.
- GO_IDLE: no eligible thread, to ST_IDLE.
- GO_HOLD: in coarse mode the current thread is not ready but not long-stalled, to ST_HOLD.

Any state can take any of these transitions at every clock edge. Synchronous reset enters ST_IDLE with the pointer at thread 0.

Top module: `mt_ctx_switch`

## Requirements
- R1: While `rst` is high at a clock edge, all register contexts clear to 0, the pointer goes to thread 0 and `issue_valid` goes low. Each thread's PC loads from its slice `start_pc[t*PCW +: PCW]`.
- R2: A write of value V to thread T, register I reads back as V on a read port whenever `issue_tid`=T. A write to one thread leaves the same register index of the other threads unchanged.
- R3: When a read port addresses the same thread and register that is being written in the same cycle, it returns the value being written (write-through bypass).
- R4: A write goes to the context named by `wr_tid`, whatever the current value of `issue_tid`.
- R5: In fine-grain mode, at each clock edge the pointer moves to the first eligible thread found by searching upward from the current thread plus one, wrapping around and ending at the current thread. `issue_valid` is high in the following cycle. Eligible means `thr_ready` high and `thr_long_stall` low.
- R6: In fine-grain mode, if no thread is eligible, `issue_valid` goes low and `issue_tid` keeps its value.
- R7: In coarse-grain mode, while the current thread has no long stall, `issue_tid` does not change, even when other threads are ready.
- R8: In coarse-grain mode, if the current thread is not ready and has no long stall, `issue_valid` goes low for that cycle and `issue_tid` is unchanged.
- R9: In coarse-grain mode, a long stall on the current thread moves the pointer at the next edge to the first eligible other thread, searching upward from the current thread plus one, and `issue_valid` is high with no lost cycle. If no other thread is eligible, `issue_valid` goes low.
- R10: In fine-grain mode, threads with `thr_long_stall` high are skipped.
- R11: A PC write to thread T takes effect at the next edge, and `issue_pc` always shows the PC of thread `issue_tid`.
- R12: In the cycle `issue_tid` changes, the read ports already return the new thread's registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mode_coarse | input | 1 | 0 = switch every cycle, 1 = switch on long stall only |
| thr_ready | input | NTHR | Per-thread ready |
| thr_long_stall | input | NTHR | Per-thread long-latency stall |
| start_pc | input | NTHR*PCW | Per-thread reset PC, thread t at bits t*PCW |
| issue_valid | output | 1 | A thread issues this cycle |
| issue_tid | output | clog2(NTHR) | Context pointer / thread to fetch |
| issue_pc | output | PCW | PC of thread `issue_tid` |
| rd_a_idx | input | clog2(NREG) | Read port A register index |
| rd_a_data | output | DW | Read port A data |
| rd_b_idx | input | clog2(NREG) | Read port B register index |
| rd_b_data | output | DW | Read port B data |
| wr_en | input | 1 | Register write enable |
| wr_tid | input | clog2(NTHR) | Thread of the written result |
| wr_idx | input | clog2(NREG) | Register index written |
| wr_data | input | DW | Write data |
| pc_wr_en | input | 1 | PC write enable |
| pc_wr_tid | input | clog2(NTHR) | Thread whose PC is written |
| pc_wr_val | input | PCW | New PC value |

## Verification
Scheduling results (`issue_valid`, `issue_tid`, `issue_pc`) are registered. They are due one edge after the inputs that decide them, so the bench drives inputs on the falling edge and checks at the next falling edge. Register reads are combinational from the pointer and the array. Bypass reads are therefore checked shortly after the inputs change, inside the same cycle, while stored values are checked in the cycle after the writing edge. The bench tracks the pointer sequence that each ready and stall pattern must produce, so every rotation and skip is checked edge by edge.

// File: rtl/mtcs_pkg.sv
package mtcs_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_HOLD  = 2'd2
    } sched_st_t;
endpackage

// File: rtl/mtcs_ctx_rf.sv
module mtcs_ctx_rf #(
    parameter int NTHR = 4,
    parameter int NREG = 8,
    parameter int DW   = 32
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [$clog2(NTHR)-1:0] rd_tid,
    input  logic [$clog2(NREG)-1:0] rd_a_idx,
    input  logic [$clog2(NREG)-1:0] rd_b_idx,
    output logic [DW-1:0]           rd_a_data,
    output logic [DW-1:0]           rd_b_data,
    input  logic                    wr_en,
    input  logic [$clog2(NTHR)-1:0] wr_tid,
    input  logic [$clog2(NREG)-1:0] wr_idx,
    input  logic [DW-1:0]           wr_data
);
    localparam int TW    = $clog2(NTHR);
    localparam int RW    = $clog2(NREG);
    localparam int DEPTH = NTHR * NREG;
    localparam int AW    = $clog2(DEPTH);
    localparam int NRD   = 2;

    function automatic logic [AW-1:0] slot(input logic [TW-1:0] t, input logic [RW-1:0] r);
        slot = AW'(int'(t) * NREG + int'(r));
    endfunction

    logic [DW-1:0] mem [DEPTH];
    logic [NRD-1:0][RW-1:0] port_idx;
    logic [NRD-1:0][DW-1:0] port_data;

    assign port_idx[0] = rd_a_idx;
    assign port_idx[1] = rd_b_idx;
    assign rd_a_data   = port_data[0];
    assign rd_b_data   = port_data[1];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (wr_en) begin
            mem[slot(wr_tid, wr_idx)] <= wr_data;
        end
    end

    generate
        for (genvar p = 0; p < NRD; p++) begin : g_rd
            logic hit;
            assign hit = wr_en && (wr_tid == rd_tid) && (wr_idx == port_idx[p]);
            always_comb begin
                if (hit) port_data[p] = wr_data;
                else     port_data[p] = mem[slot(rd_tid, port_idx[p])];
            end
        end
    endgenerate

    // R2
    stored_value_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(wr_en) && !$past(rst) && !wr_en && rd_tid == $past(wr_tid) && rd_a_idx == $past(wr_idx))
        |-> rd_a_data == $past(wr_data));
    // R3
    bypass_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_tid == rd_tid && wr_idx == rd_b_idx) |-> rd_b_data == wr_data);
endmodule

// File: rtl/mtcs_pc_bank.sv
module mtcs_pc_bank #(
    parameter int NTHR = 4,
    parameter int PCW  = 32
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [NTHR*PCW-1:0]     start_pc,
    input  logic                    pc_wr_en,
    input  logic [$clog2(NTHR)-1:0] pc_wr_tid,
    input  logic [PCW-1:0]          pc_wr_val,
    input  logic [$clog2(NTHR)-1:0] rd_tid,
    output logic [PCW-1:0]          pc_out
);
    localparam int TW = $clog2(NTHR);

    logic [PCW-1:0] pc_q [NTHR];

    generate
        for (genvar t = 0; t < NTHR; t++) begin : g_pc
            always_ff @(posedge clk) begin
                if (rst)
                    pc_q[t] <= start_pc[t*PCW +: PCW];
                else if (pc_wr_en && pc_wr_tid == TW'(t))
                    pc_q[t] <= pc_wr_val;
            end
        end
    endgenerate

    assign pc_out = pc_q[rd_tid];

    // R11
    pc_write_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(pc_wr_en) && !$past(rst) && rd_tid == $past(pc_wr_tid))
        |-> pc_out == $past(pc_wr_val));
endmodule

// File: rtl/mtcs_sched.sv
module mtcs_sched
    import mtcs_pkg::*;
#(
    parameter int NTHR = 4
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    mode_coarse,
    input  logic [NTHR-1:0]         thr_ready,
    input  logic [NTHR-1:0]         thr_long_stall,
    output logic [$clog2(NTHR)-1:0] ctx_ptr,
    output logic                    issue_valid
);
    localparam int TW = $clog2(NTHR);

    sched_st_t     state_q, state_d;
    logic [TW-1:0] ptr_q, ptr_d;
    logic [NTHR-1:0] elig;
    logic          pick_found;
    logic [TW-1:0] pick_tid;

    assign elig = thr_ready & ~thr_long_stall;

    // Round-robin search after the current thread; coarse mode leaves the
    // current thread out because it only searches when that thread stalls.
    always_comb begin
        logic [TW-1:0] cand;
        int lim;
        lim        = mode_coarse ? NTHR - 1 : NTHR;
        pick_found = 1'b0;
        pick_tid   = ptr_q;
        for (int k = 1; k <= NTHR; k++) begin
            cand = TW'((int'(ptr_q) + k) % NTHR);
            if (k <= lim && !pick_found && elig[cand]) begin
                pick_found = 1'b1;
                pick_tid   = cand;
            end
        end
    end

    // Next state: GO_ISSUE, GO_IDLE or GO_HOLD from any state.
    always_comb begin
        state_d = ST_IDLE;
        ptr_d   = ptr_q;
        if (!mode_coarse || thr_long_stall[ptr_q]) begin
            if (pick_found) begin
                state_d = ST_ISSUE;
                ptr_d   = pick_tid;
            end else begin
                state_d = ST_IDLE;
            end
        end else if (thr_ready[ptr_q]) begin
            state_d = ST_ISSUE;
        end else begin
            state_d = ST_HOLD;
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            ptr_q   <= '0;
        end else begin
            state_q <= state_d;
            ptr_q   <= ptr_d;
        end
    end

    // Outputs.
    always_comb begin
        unique case (state_q)
            ST_IDLE:  issue_valid = 1'b0;
            ST_ISSUE: issue_valid = 1'b1;
            ST_HOLD:  issue_valid = 1'b0;
            default:  issue_valid = 1'b0;
        endcase
    end
    assign ctx_ptr = ptr_q;

    // R1
    reset_state_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!issue_valid && ctx_ptr == '0));
    // R5
    fine_issue_chk: assert property (@(posedge clk) disable iff (rst)
        (!mode_coarse && (thr_ready & ~thr_long_stall) != '0) |=> issue_valid);
    // R6
    fine_none_chk: assert property (@(posedge clk) disable iff (rst)
        (!mode_coarse && (thr_ready & ~thr_long_stall) == '0) |=> (!issue_valid && $stable(ctx_ptr)));
    // R7
    coarse_stay_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_coarse && !thr_long_stall[ctx_ptr]) |=> $stable(ctx_ptr));
    // R9
    coarse_switch_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_coarse && thr_long_stall[ctx_ptr]) |=> (!$stable(ctx_ptr) || !issue_valid));
endmodule

// File: rtl/mt_ctx_switch.sv
module mt_ctx_switch #(
    parameter int NTHR = 4,
    parameter int NREG = 8,
    parameter int DW   = 32,
    parameter int PCW  = 32
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    mode_coarse,
    input  logic [NTHR-1:0]         thr_ready,
    input  logic [NTHR-1:0]         thr_long_stall,
    input  logic [NTHR*PCW-1:0]     start_pc,
    output logic                    issue_valid,
    output logic [$clog2(NTHR)-1:0] issue_tid,
    output logic [PCW-1:0]          issue_pc,
    input  logic [$clog2(NREG)-1:0] rd_a_idx,
    output logic [DW-1:0]           rd_a_data,
    input  logic [$clog2(NREG)-1:0] rd_b_idx,
    output logic [DW-1:0]           rd_b_data,
    input  logic                    wr_en,
    input  logic [$clog2(NTHR)-1:0] wr_tid,
    input  logic [$clog2(NREG)-1:0] wr_idx,
    input  logic [DW-1:0]           wr_data,
    input  logic                    pc_wr_en,
    input  logic [$clog2(NTHR)-1:0] pc_wr_tid,
    input  logic [PCW-1:0]          pc_wr_val
);
    localparam int TW = $clog2(NTHR);

    logic [TW-1:0] ctx_ptr;

    mtcs_sched #(.NTHR(NTHR)) u_sched (
        .clk(clk), .rst(rst), .mode_coarse(mode_coarse),
        .thr_ready(thr_ready), .thr_long_stall(thr_long_stall),
        .ctx_ptr(ctx_ptr), .issue_valid(issue_valid)
    );

    mtcs_ctx_rf #(.NTHR(NTHR), .NREG(NREG), .DW(DW)) u_rf (
        .clk(clk), .rst(rst), .rd_tid(ctx_ptr),
        .rd_a_idx(rd_a_idx), .rd_b_idx(rd_b_idx),
        .rd_a_data(rd_a_data), .rd_b_data(rd_b_data),
        .wr_en(wr_en), .wr_tid(wr_tid), .wr_idx(wr_idx), .wr_data(wr_data)
    );

    mtcs_pc_bank #(.NTHR(NTHR), .PCW(PCW)) u_pc (
        .clk(clk), .rst(rst), .start_pc(start_pc),
        .pc_wr_en(pc_wr_en), .pc_wr_tid(pc_wr_tid), .pc_wr_val(pc_wr_val),
        .rd_tid(ctx_ptr), .pc_out(issue_pc)
    );

    assign issue_tid = ctx_ptr;
endmodule

// File: tb/mt_ctx_switch_tb.sv
`timescale 1ns/1ps
module mt_ctx_switch_tb;
    localparam int NTHR = 4, NREG = 8, DW = 32, PCW = 32;

    logic clk = 0, rst = 1, mode_coarse = 0;
    logic [NTHR-1:0] thr_ready = '0, thr_long_stall = '0;
    logic [NTHR*PCW-1:0] start_pc;
    logic issue_valid;
    logic [1:0] issue_tid;
    logic [PCW-1:0] issue_pc;
    logic [2:0] rd_a_idx = '0, rd_b_idx = '0;
    logic [DW-1:0] rd_a_data, rd_b_data;
    logic wr_en = 0;
    logic [1:0] wr_tid = '0;
    logic [2:0] wr_idx = '0;
    logic [DW-1:0] wr_data = '0;
    logic pc_wr_en = 0;
    logic [1:0] pc_wr_tid = '0;
    logic [PCW-1:0] pc_wr_val = '0;

    int nchk = 0, nerr = 0;

    always #10 clk = ~clk;

    mt_ctx_switch #(.NTHR(NTHR), .NREG(NREG), .DW(DW), .PCW(PCW)) u_dut (.*);

    function automatic logic [PCW-1:0] spc(input int t);
        return PCW'(32'h1000 * (t + 1));
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic expect_issue(input string req, input logic v, input int t);
        chk({req, " valid"}, 64'(issue_valid), 64'(v));
        chk({req, " tid"}, 64'(issue_tid), 64'(t));
    endtask

    task automatic t_reset();
        for (int t = 0; t < NTHR; t++) start_pc[t*PCW +: PCW] = spc(t);
        rst = 1;
        repeat (3) tick();
        rst = 0;
        expect_issue("R1", 1'b0, 0);
        chk("R1 pc", 64'(issue_pc), 64'(spc(0)));
        for (int r = 0; r < NREG; r++) begin
            rd_a_idx = 3'(r);
            #1 chk("R1 reg clear", 64'(rd_a_data), 64'd0);
        end
    endtask

    task automatic t_regs();
        mode_coarse = 1; thr_ready = '0;
        wr_en = 1; wr_tid = 0; wr_idx = 3; wr_data = 32'hAAAA_0003;
        tick();
        wr_tid = 2; wr_data = 32'hBBBB_0203;
        tick();
        wr_tid = 1; wr_data = 32'hDDDD_0103;
        tick();
        wr_en = 0;
        rd_a_idx = 3;
        #1;
        chk("R4 ctx still 0", 64'(issue_tid), 64'd0);
        chk("R2/R4 thread0 r3 untouched by others", 64'(rd_a_data), 64'hAAAA_0003);
    endtask

    task automatic t_bypass();
        wr_en = 1; wr_tid = 0; wr_idx = 5; wr_data = 32'hC0FF_EE05;
        rd_a_idx = 5; rd_b_idx = 5;
        #1;
        chk("R3 port A bypass", 64'(rd_a_data), 64'hC0FF_EE05);
        chk("R3 port B bypass", 64'(rd_b_data), 64'hC0FF_EE05);
        tick();
        wr_en = 0;
        #1 chk("R2 stored", 64'(rd_b_data), 64'hC0FF_EE05);
    endtask

    task automatic t_fine();
        int seq[4] = '{1, 2, 3, 0};
        int alt[3] = '{1, 3, 1};
        int skp[4] = '{3, 0, 1, 3};
        mode_coarse = 0; thr_ready = 4'b1111; rd_a_idx = 3;
        foreach (seq[i]) begin
            tick();
            expect_issue("R5 rotate", 1'b1, seq[i]);
            chk("R11 pc follows tid", 64'(issue_pc), 64'(spc(seq[i])));
            if (seq[i] == 1) chk("R12 t1 r3", 64'(rd_a_data), 64'hDDDD_0103);
            if (seq[i] == 2) chk("R12 t2 r3", 64'(rd_a_data), 64'hBBBB_0203);
        end
        thr_ready = 4'b1010;
        foreach (alt[i]) begin
            tick();
            expect_issue("R5 subset", 1'b1, alt[i]);
        end
        thr_ready = 4'b1111; thr_long_stall = 4'b0100;
        foreach (skp[i]) begin
            tick();
            expect_issue("R10 skip stalled", 1'b1, skp[i]);
        end
        thr_ready = '0; thr_long_stall = '0;
        tick(); expect_issue("R6 none ready", 1'b0, 3);
        tick(); expect_issue("R6 none ready hold", 1'b0, 3);
    endtask

    task automatic t_coarse();
        mode_coarse = 1; thr_ready = 4'b1111;
        for (int i = 0; i < 4; i++) begin
            tick(); expect_issue("R7 stay", 1'b1, 3);
        end
        thr_ready = 4'b0111;
        tick(); expect_issue("R8 short stall bubble", 1'b0, 3);
        thr_ready = 4'b1111;
        tick(); expect_issue("R8 resume", 1'b1, 3);
        thr_long_stall = 4'b1000;
        tick(); expect_issue("R9 switch", 1'b1, 0);
        tick(); expect_issue("R7 stay after switch", 1'b1, 0);
        thr_long_stall = 4'b0001; thr_ready = 4'b0001;
        tick(); expect_issue("R9 no other eligible", 1'b0, 0);
        thr_long_stall = '0;
        tick(); expect_issue("R9 back on", 1'b1, 0);
        thr_long_stall = 4'b0001; thr_ready = 4'b1101;
        tick(); expect_issue("R9 skip unready", 1'b1, 2);
        rd_a_idx = 3;
        #1 chk("R12 t2 r3 after switch", 64'(rd_a_data), 64'hBBBB_0203);
    endtask

    task automatic t_pc();
        pc_wr_en = 1; pc_wr_tid = 2; pc_wr_val = 32'h0000_1234;
        tick();
        chk("R11 pc write", 64'(issue_pc), 64'h1234);
        pc_wr_tid = 1; pc_wr_val = 32'h0000_9999;
        tick();
        pc_wr_en = 0;
        chk("R11 other thread pc", 64'(issue_pc), 64'h1234);
        chk("R7 tid kept", 64'(issue_tid), 64'd2);
    endtask

    initial begin
        #(20.0 * 200000);
        nchk++; nerr++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_regs();
        t_bypass();
        t_fine();
        t_coarse();
        t_pc();
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end
endmodule